// File: doc/BRIEF.md
# DMA Channel Control and Reload

This block keeps the control state of one DMA channel: the enable bit that software sets and clears, a separate active status bit that tells whether the channel is really running, and the working source address, destination address and remaining byte count. Alongside the working set it holds a reload set of the same three values. When the count runs out, the channel either loads the reload set and carries on with the next buffer, or it shuts down.

A transfer engine drives the burst and beat inputs. Each beat consumes a number of bytes, and each address steps forward by that amount when its increment is switched on. Each cause of shutdown has its own timing. A bus error stops the channel on the next edge. An exhausted count without reload, or a disable from software, waits until the current burst has finished. Whenever the active bit drops, the enable bit drops with it. Software writes all registers through a single write port. Two sticky flags, one for count exhaustion and one for bus errors, are cleared by writing 1.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, chan_en, chan_active, src_addr, dst_addr, byte_count, ctz_irq and err_flag are all 0.
- R2: A write to the control register (wr_addr 0) with data bit 0 set makes chan_en and chan_active both 1 on the next edge.
- R3: While active, each beat_valid cycle lowers byte_count by beat_bytes. It raises src_addr by beat_bytes if control bit 3 is set, and dst_addr by beat_bytes if control bit 4 is set. Beats while inactive change nothing.
- R4: A bus_err while active clears chan_active and chan_en on the next edge, even inside a burst, and sets err_flag.
- R5: When a beat empties the count and reload is off (control bit 1 clear), chan_active stays 1 until burst_done. It then clears on that edge. If no burst is open, it clears on the next edge.
- R6: A control write with bit 0 clear during a burst clears chan_en at once, but chan_active stays 1 until burst_done. Outside a burst, chan_active clears on the next edge.
- R7: In every cycle where chan_active has just fallen from 1 to 0, chan_en is 0.
- R8: When a beat empties the count and reload is on (control bit 1 set), src_addr, dst_addr and byte_count take the reload register values on the next edge, and chan_active stays 1.
- R9: Emptying the count sets ctz_irq only when control bit 2 is set. ctz_irq then stays 1 until a write to wr_addr 1 with data bit 0 set.
- R10: err_flag stays 1 until a write to wr_addr 1 with data bit 1 set. Clearing one flag leaves the other flag unchanged.
- R11: The write map is: 2 working source, 3 working destination, 4 working count (low 24 bits), 5 reload source, 6 reload destination, 7 reload count.
- R12: A beat whose beat_bytes is at least the remaining count empties the count: byte_count becomes 0 (without reload) and the count-exhausted event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| burst_start | input | 1 | Engine opens a burst |
| burst_done | input | 1 | Engine closes the current burst |
| beat_valid | input | 1 | One data beat moved this cycle |
| beat_bytes | input | 3 | Bytes moved by this beat |
| bus_err | input | 1 | Bus error reported by the engine |
| chan_en | output | 1 | Enable bit |
| chan_active | output | 1 | Active status bit |
| src_addr | output | 32 | Working source address |
| dst_addr | output | 32 | Working destination address |
| byte_count | output | 24 | Working remaining byte count |
| ctz_irq | output | 1 | Sticky count-exhausted flag |
| err_flag | output | 1 | Sticky bus error flag |

## Verification
The assertions assume that the engine keeps its burst handshake well formed: a burst_done only closes a burst it opened, and beats and errors arrive only while the channel is active. They also assume that software does not write the control or flag register in the same cycle as the events under test. The directed bench drives every engine strobe for exactly one cycle, after the falling edge. It opens a burst before sending beats, and it places register writes in idle cycles, so every property sees the inputs it relies on.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_FLAGS = 3'd1;
    localparam logic [SEL_W-1:0] SEL_SRC   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DST   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CNT   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_RSRC  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_RDST  = 3'd6;
    localparam logic [SEL_W-1:0] SEL_RCNT  = 3'd7;

    localparam int CB_EN   = 0;
    localparam int CB_RLD  = 1;
    localparam int CB_IRQ  = 2;
    localparam int CB_SINC = 3;
    localparam int CB_DINC = 4;
    localparam int CTRL_W  = 5;

    localparam int FB_CTZ = 0;
    localparam int FB_ERR = 1;
    localparam int FLAG_W = 2;

    typedef struct packed {
        logic en;
        logic active;
        logic in_burst;
        logic stop_pend;
        logic rld_en;
        logic irq_en;
        logic src_inc;
        logic dst_inc;
        logic ctz_flag;
        logic err_flag;
    } chan_state_t;
endpackage

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_bits,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flag_bits,
    input  logic              burst_start,
    input  logic              burst_done,
    input  logic              bus_err,
    input  logic              ctz_now,
    output logic              en,
    output logic              active,
    output logic              in_burst,
    output logic              rld_en,
    output logic              irq_en,
    output logic              src_inc,
    output logic              dst_inc,
    output logic              ctz_flag,
    output logic              err_flag
);
    chan_state_t st_d, st_q;
    logic        dis_req;
    logic        ctz_stop;
    logic        term;

    always_comb begin
        st_d     = st_q;
        dis_req  = ctrl_wr && !ctrl_bits[CB_EN] && st_q.active;
        ctz_stop = ctz_now && !st_q.rld_en;
        term     = 1'b0;

        if (ctrl_wr) begin
            st_d.en      = ctrl_bits[CB_EN];
            st_d.rld_en  = ctrl_bits[CB_RLD];
            st_d.irq_en  = ctrl_bits[CB_IRQ];
            st_d.src_inc = ctrl_bits[CB_SINC];
            st_d.dst_inc = ctrl_bits[CB_DINC];
        end
        if (flag_wr) begin
            if (flag_bits[FB_CTZ]) st_d.ctz_flag = 1'b0;
            if (flag_bits[FB_ERR]) st_d.err_flag = 1'b0;
        end

        if (st_q.active) begin
            if (burst_start && !st_q.in_burst) st_d.in_burst = 1'b1;
            if (burst_done)                    st_d.in_burst = 1'b0;
            if (bus_err) begin
                st_d.active    = 1'b0;
                st_d.en        = 1'b0;
                st_d.in_burst  = 1'b0;
                st_d.stop_pend = 1'b0;
                st_d.err_flag  = 1'b1;
            end else begin
                term = st_q.stop_pend || ctz_stop || dis_req;
                if (term && (burst_done || !st_q.in_burst)) begin
                    st_d.active    = 1'b0;
                    st_d.en        = 1'b0;
                    st_d.in_burst  = 1'b0;
                    st_d.stop_pend = 1'b0;
                end else begin
                    st_d.stop_pend = term;
                end
            end
        end else if (ctrl_wr && ctrl_bits[CB_EN]) begin
            st_d.active = 1'b1;
        end

        if (ctz_now && st_q.irq_en) st_d.ctz_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en       = st_q.en;
    assign active   = st_q.active;
    assign in_burst = st_q.in_burst;
    assign rld_en   = st_q.rld_en;
    assign irq_en   = st_q.irq_en;
    assign src_inc  = st_q.src_inc;
    assign dst_inc  = st_q.dst_inc;
    assign ctz_flag = st_q.ctz_flag;
    assign err_flag = st_q.err_flag;
endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              bus_err,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic              rld_en,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  byte_count,
    output logic              ctz_now
);
    localparam int NPTR = 2;

    typedef struct packed {
        logic [NPTR-1:0][ADDR_W-1:0] ptr;
        logic [NPTR-1:0][ADDR_W-1:0] rld_ptr;
        logic [CNT_W-1:0]            cnt;
        logic [CNT_W-1:0]            rld_cnt;
    } xfer_t;

    xfer_t             x_d, x_q;
    logic              beat_ok;
    logic [CNT_W-1:0]  step_cnt;
    logic [ADDR_W-1:0] step_adr;
    logic [NPTR-1:0]   inc_on;
    logic [NPTR-1:0][SEL_W-1:0] sel_wk;
    logic [NPTR-1:0][SEL_W-1:0] sel_rl;

    assign step_cnt = {{(CNT_W-BEAT_W){1'b0}}, beat_bytes};
    assign step_adr = {{(ADDR_W-BEAT_W){1'b0}}, beat_bytes};
    assign beat_ok  = beat_valid && active && !bus_err;
    assign ctz_now  = beat_ok && (x_q.cnt <= step_cnt);
    assign inc_on   = {dst_inc, src_inc};
    assign sel_wk   = {SEL_DST, SEL_SRC};
    assign sel_rl   = {SEL_RDST, SEL_RSRC};

    always_comb begin
        x_d = x_q;
        if (wr_en) begin
            for (int i = 0; i < NPTR; i++) begin
                if (wr_addr == sel_wk[i]) x_d.ptr[i]     = wr_data;
                if (wr_addr == sel_rl[i]) x_d.rld_ptr[i] = wr_data;
            end
            if (wr_addr == SEL_CNT)  x_d.cnt     = wr_data[CNT_W-1:0];
            if (wr_addr == SEL_RCNT) x_d.rld_cnt = wr_data[CNT_W-1:0];
        end
        if (beat_ok) begin
            if (ctz_now && rld_en) begin
                x_d.ptr = x_q.rld_ptr;
                x_d.cnt = x_q.rld_cnt;
            end else begin
                x_d.cnt = ctz_now ? '0 : (x_q.cnt - step_cnt);
                for (int i = 0; i < NPTR; i++) begin
                    if (inc_on[i]) x_d.ptr[i] = x_q.ptr[i] + step_adr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign src_addr   = x_q.ptr[0];
    assign dst_addr   = x_q.ptr[1];
    assign byte_count = x_q.cnt;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              burst_start,
    input  logic              burst_done,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic              bus_err,
    output logic              chan_en,
    output logic              chan_active,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  byte_count,
    output logic              ctz_irq,
    output logic              err_flag
);
    logic ctrl_wr, flag_wr, ctz_now, in_burst;
    logic rld_en, irq_en, src_inc, dst_inc;

    assign ctrl_wr = wr_en && (wr_addr == SEL_CTRL);
    assign flag_wr = wr_en && (wr_addr == SEL_FLAGS);

    dma_chan_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_bits   (wr_data[CTRL_W-1:0]),
        .flag_wr     (flag_wr),
        .flag_bits   (wr_data[FLAG_W-1:0]),
        .burst_start (burst_start),
        .burst_done  (burst_done),
        .bus_err     (bus_err),
        .ctz_now     (ctz_now),
        .en          (chan_en),
        .active      (chan_active),
        .in_burst    (in_burst),
        .rld_en      (rld_en),
        .irq_en      (irq_en),
        .src_inc     (src_inc),
        .dst_inc     (dst_inc),
        .ctz_flag    (ctz_irq),
        .err_flag    (err_flag)
    );

    dma_chan_xfer #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .BEAT_W (BEAT_W)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (chan_active),
        .bus_err    (bus_err),
        .beat_valid (beat_valid),
        .beat_bytes (beat_bytes),
        .rld_en     (rld_en),
        .src_inc    (src_inc),
        .dst_inc    (dst_inc),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .byte_count (byte_count),
        .ctz_now    (ctz_now)
    );
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int BEAT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [ADDR_W-1:0] wr_data,
    input logic              burst_done,
    input logic              beat_valid,
    input logic [BEAT_W-1:0] beat_bytes,
    input logic              bus_err,
    input logic              chan_en,
    input logic              chan_active,
    input logic              in_burst,
    input logic              rld_en,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [CNT_W-1:0]  byte_count,
    input logic              ctz_irq,
    input logic              err_flag
);
    logic              ctz_clr;
    logic [CNT_W-1:0]  bb_ext;

    assign ctz_clr = wr_en && (wr_addr == 3'd1) && wr_data[0];
    assign bb_ext  = {{(CNT_W-BEAT_W){1'b0}}, beat_bytes};

    // R7: active falling always comes with enable low
    a_r7_fall_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_active) |-> !chan_en);

    // R4: bus error stops the channel on the next edge and flags it
    a_r4_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && bus_err) |=> (!chan_active && !chan_en && err_flag));

    // R5 / R6: nothing but an error ends activity inside an open burst
    a_r6_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && in_burst && !burst_done && !bus_err) |=> chan_active);

    // R3: an idle channel ignores beats
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_active && !wr_en) |=> ($stable(byte_count) && $stable(src_addr) && $stable(dst_addr)));

    // R8: exhausting the count with reload keeps the channel running
    a_r8_reload_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && beat_valid && !bus_err && !wr_en && rld_en && (byte_count <= bb_ext))
        |=> chan_active);

    // R9: count-exhausted flag is sticky
    a_r9_ctz_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctz_irq && !ctz_clr) |=> ctz_irq);

    // R10: error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(wr_en && (wr_addr == 3'd1) && wr_data[1])) |=> err_flag);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .burst_done  (burst_done),
    .beat_valid  (beat_valid),
    .beat_bytes  (beat_bytes),
    .bus_err     (bus_err),
    .chan_en     (chan_en),
    .chan_active (chan_active),
    .in_burst    (in_burst),
    .rld_en      (rld_en),
    .src_addr    (src_addr),
    .dst_addr    (dst_addr),
    .byte_count  (byte_count),
    .ctz_irq     (ctz_irq),
    .err_flag    (err_flag)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        burst_start = 1'b0, burst_done = 1'b0, beat_valid = 1'b0, bus_err = 1'b0;
    logic [2:0]  beat_bytes = '0;
    logic        chan_en, chan_active, ctz_irq, err_flag;
    logic [31:0] src_addr, dst_addr;
    logic [23:0] byte_count;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    dma_chan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .burst_start(burst_start), .burst_done(burst_done), .beat_valid(beat_valid),
        .beat_bytes(beat_bytes), .bus_err(bus_err), .chan_en(chan_en),
        .chan_active(chan_active), .src_addr(src_addr), .dst_addr(dst_addr),
        .byte_count(byte_count), .ctz_irq(ctz_irq), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    // one cycle of engine strobes, then back to idle
    task automatic cyc(input logic bs, input logic bv, input logic [2:0] bb,
                       input logic bd, input logic be);
        burst_start = bs; beat_valid = bv; beat_bytes = bb; burst_done = bd; bus_err = be;
        @(negedge clk);
        burst_start = 1'b0; beat_valid = 1'b0; beat_bytes = '0; burst_done = 1'b0; bus_err = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 en", {31'd0, chan_en}, 0);
        chk("R1 active", {31'd0, chan_active}, 0);
        chk("R1 src", src_addr, 0);
        chk("R1 dst", dst_addr, 0);
        chk("R1 cnt", {8'd0, byte_count}, 0);
        chk("R1 flags", {30'd0, ctz_irq, err_flag}, 0);
    endtask

    task automatic t_beats;
        wr(3'd2, 32'h1000);
        wr(3'd3, 32'h2000);
        wr(3'd4, 32'd100);
        chk("R11 src write", src_addr, 32'h1000);
        chk("R11 dst write", dst_addr, 32'h2000);
        chk("R11 cnt write", {8'd0, byte_count}, 100);
        cyc(1, 1, 3'd4, 0, 0);  // idle channel: ignored
        chk("R3 idle beat ignored", {8'd0, byte_count}, 100);
        wr(3'd0, 32'h09);        // en + src_inc
        chk("R2 en", {31'd0, chan_en}, 1);
        chk("R2 active", {31'd0, chan_active}, 1);
        cyc(1, 0, 3'd0, 0, 0);
        cyc(0, 1, 3'd4, 0, 0);
        cyc(0, 1, 3'd3, 0, 0);
        chk("R3 cnt", {8'd0, byte_count}, 93);
        chk("R3 src inc", src_addr, 32'h1007);
        chk("R3 dst held", dst_addr, 32'h2000);
        cyc(0, 0, 3'd0, 1, 0);
        wr(3'd0, 32'h11);        // dst_inc only, still enabled
        cyc(1, 1, 3'd2, 0, 0);
        chk("R3 dst inc", dst_addr, 32'h2002);
        chk("R3 src held", src_addr, 32'h1007);
        cyc(0, 0, 3'd0, 1, 0);
    endtask

    task automatic t_disable;
        cyc(1, 0, 3'd0, 0, 0);
        wr(3'd0, 32'h0);
        chk("R6 en cleared at once", {31'd0, chan_en}, 0);
        chk("R6 active held in burst", {31'd0, chan_active}, 1);
        cyc(0, 0, 3'd0, 0, 0);
        chk("R6 still active", {31'd0, chan_active}, 1);
        cyc(0, 0, 3'd0, 1, 0);
        chk("R6 off at burst end", {31'd0, chan_active}, 0);
        chk("R7 en low", {31'd0, chan_en}, 0);
        wr(3'd0, 32'h1);
        wr(3'd0, 32'h0);
        chk("R6 immediate outside burst", {31'd0, chan_active}, 0);
    endtask

    task automatic t_bus_err;
        wr(3'd4, 32'd50);
        wr(3'd0, 32'h1);
        cyc(1, 1, 3'd4, 0, 0);
        cyc(0, 0, 3'd0, 0, 1);
        chk("R4 active", {31'd0, chan_active}, 0);
        chk("R4 en", {31'd0, chan_en}, 0);
        chk("R4 err_flag", {31'd0, err_flag}, 1);
        chk("R4 cnt frozen", {8'd0, byte_count}, 46);
        wr(3'd1, 32'h1);
        chk("R10 err kept on ctz clear", {31'd0, err_flag}, 1);
        wr(3'd1, 32'h2);
        chk("R10 err cleared", {31'd0, err_flag}, 0);
    endtask

    task automatic t_ctz_stop;
        wr(3'd4, 32'd6);
        wr(3'd0, 32'h5);         // en + irq
        cyc(1, 1, 3'd4, 0, 0);
        chk("R3 cnt 2", {8'd0, byte_count}, 2);
        cyc(0, 1, 3'd4, 0, 0);
        chk("R12 cnt clamps", {8'd0, byte_count}, 0);
        chk("R9 flag set", {31'd0, ctz_irq}, 1);
        chk("R5 active until burst end", {31'd0, chan_active}, 1);
        cyc(0, 0, 3'd0, 0, 0);
        chk("R5 still active", {31'd0, chan_active}, 1);
        chk("R9 sticky", {31'd0, ctz_irq}, 1);
        cyc(0, 0, 3'd0, 1, 0);
        chk("R5 stopped", {31'd0, chan_active}, 0);
        chk("R7 en forced low", {31'd0, chan_en}, 0);
        wr(3'd1, 32'h1);
        chk("R9 cleared", {31'd0, ctz_irq}, 0);
        wr(3'd4, 32'd2);
        wr(3'd0, 32'h1);         // irq disabled
        cyc(0, 1, 3'd2, 0, 0);
        chk("R9 no flag when off", {31'd0, ctz_irq}, 0);
        chk("R5 no burst: immediate", {31'd0, chan_active}, 0);
    endtask

    task automatic t_reload;
        wr(3'd5, 32'h5000);
        wr(3'd6, 32'h6000);
        wr(3'd7, 32'd16);
        wr(3'd2, 32'h100);
        wr(3'd4, 32'd4);
        wr(3'd0, 32'h1B);        // en + reload + src_inc + dst_inc
        cyc(1, 1, 3'd4, 0, 0);
        chk("R8 src", src_addr, 32'h5000);
        chk("R8 dst", dst_addr, 32'h6000);
        chk("R8 cnt", {8'd0, byte_count}, 16);
        cyc(0, 0, 3'd0, 1, 0);
        chk("R8 stays active", {31'd0, chan_active}, 1);
        chk("R8 en kept", {31'd0, chan_en}, 1);
        cyc(1, 1, 3'd4, 0, 0);
        chk("R8 continues", src_addr, 32'h5004);
        cyc(0, 0, 3'd0, 1, 0);
        wr(3'd0, 32'h0);
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_beats();
        t_disable();
        t_bus_err();
        t_ctz_stop();
        t_reload();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule